// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash bus. It works out whether a program or erase that the host has already launched has finished. It does this by reading the status byte and watching a bit that the device inverts on every read while an embedded operation runs. A start pulse begins a poll.

- The block reads pairs of status bytes and compares the chosen toggle bit across each pair.
- A steady bit means the operation is finished.
- A moving bit together with the device's time-limit flag (bit 5) calls for one more confirming pair. The bit may have gone quiet in the same instant that the flag rose, so this extra pair is needed before failure is declared.
- Only continued toggling on that confirming pair is treated as a failed operation. The block then puts the device back into array-read mode with a single reset command write.

The monitored bit is chosen at run time: bit 6 shows whether an erase is in progress, and bit 2 shows which sectors are being erased. Polling can be given up at any moment with an abort input. A later start always begins again with a fresh read pair and reuses no earlier sample. A poll budget, counted in read pairs, ends a run that never sees the flag rise.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, busy_o, rd_req_o, wr_req_o, done_ok_o, done_fail_o and timeout_o are all 0.
- R2: A start_i pulse while idle raises busy_o on the next cycle. busy_o stays 1 until the cycle in which exactly one of done_ok_o or done_fail_o pulses for one cycle, and busy_o is 0 in that cycle.
- R3: Each poll round is two consecutive reads. If the monitored bit has the same value in both reads, the run ends with done_ok_o, after exactly those reads and with no write.
- R4: If the monitored bit differs within a round and bit 5 of the second byte is 0, a new two-read round follows.
- R5: If the monitored bit differs and bit 5 of the second byte is 1, a confirming round of two reads follows. If the monitored bit is equal across that confirming round, the run ends with done_ok_o and no write.
- R6: If the monitored bit differs in the confirming round, the block makes exactly one write with wr_data_o = 0xF0. It then pulses done_fail_o with timeout_o = 0.
- R7: With tog_sel_i = 0 the monitored bit is bit 6; with tog_sel_i = 1 it is bit 2. The bit that is not selected has no effect on the outcome.
- R8: After MAX_POLLS ordinary rounds that all toggle with bit 5 = 0, done_fail_o and timeout_o pulse together. No write is made.
- R9: abort_i returns the block to idle with no done pulse, even in a cycle that also carries a read acknowledge. The next run starts with a fresh two-read round.
- R10: start_i while busy_o is 1 has no effect on the sequence of reads or on the outcome.
- R11: If the monitored bit is steady in the same read in which bit 5 first reads as 1, the run ends with done_ok_o. No confirming round is made.
- R12: rd_req_o stays high until rd_ack_i. wr_req_o stays high until wr_ack_i. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll run (taken when idle) |
| abort_i | input | 1 | Give up the current run |
| tog_sel_i | input | 1 | 0: watch bit 6, 1: watch bit 2 |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read complete, rd_data_i valid |
| rd_data_i | input | DATA_W | Status byte returned by the device |
| wr_req_o | output | 1 | Command write request |
| wr_ack_i | input | 1 | Write complete |
| wr_data_o | output | DATA_W | Command byte (reset command) |
| busy_o | output | 1 | A run is in progress |
| done_ok_o | output | 1 | One-cycle pulse: operation finished |
| done_fail_o | output | 1 | One-cycle pulse: operation failed or timed out |
| timeout_o | output | 1 | Qualifies done_fail_o as a poll-budget expiry |

## Verification
The two checks that can land on the same read are the pair comparison and the test of the time-limit flag. The bench feeds a byte in which bit 5 rises at the same moment the monitored bit stops toggling. It then judges that the run closes as a success after two reads, with no confirming round and no write. A second collision is an abort raised in the very cycle that a read is acknowledged. That run must end silently, and the following run must begin from a fresh pair.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_RD_A,
      PS_RD_B,
      PS_CHK_A,
      PS_CHK_B,
      PS_RST_WR
   } tpoll_state_e;
endpackage

// File: rtl/tpoll_bit_pick.sv
module tpoll_bit_pick #(
   parameter int DATA_W  = 8,
   parameter int BIT_A   = 6,
   parameter int BIT_B   = 2,
   parameter int FLAG_BIT = 5
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic              sel_i,
   output logic              tog_o,
   output logic              flag_o
);
   generate
      if (BIT_A >= DATA_W || BIT_B >= DATA_W || FLAG_BIT >= DATA_W) begin : g_bad_bit
         $error("tpoll_bit_pick: bit index outside data width");
      end
      if (BIT_A == BIT_B) begin : g_single
         assign tog_o = byte_i[BIT_A];
      end else begin : g_dual
         assign tog_o = sel_i ? byte_i[BIT_B] : byte_i[BIT_A];
      end
   endgenerate
   assign flag_o = byte_i[FLAG_BIT];
endmodule

// File: rtl/tpoll_round_cnt.sv
module tpoll_round_cnt #(
   parameter int MAX_POLLS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   generate
      if (MAX_POLLS == 0) begin : g_unbounded
         assign last_o = 1'b0;
      end else begin : g_bounded
         localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
         localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
   import tpoll_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter int              BIT_A     = 6,
   parameter int              BIT_B     = 2,
   parameter int              FLAG_BIT  = 5,
   parameter int              MAX_POLLS = 64,
   parameter logic [DATA_W-1:0] RST_CMD = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              tog_sel_i,
   output logic              rd_req_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_req_o,
   input  logic              wr_ack_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_ok_o,
   output logic              done_fail_o,
   output logic              timeout_o
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("toggle_poll_ctrl: DATA_W must be at least 8");
      end
      if (MAX_POLLS < 0) begin : g_bad_polls
         $error("toggle_poll_ctrl: MAX_POLLS must not be negative");
      end
   endgenerate

   tpoll_state_e st_q, st_d;
   logic first_q;
   logic tog_now, flag_now, last_round;
   logic ok_d, fail_d, tmo_d;
   logic ok_q, fail_q, tmo_q;
   logic round_clr, round_inc;

   tpoll_bit_pick #(
      .DATA_W(DATA_W), .BIT_A(BIT_A), .BIT_B(BIT_B), .FLAG_BIT(FLAG_BIT)
   ) u_pick (
      .byte_i(rd_data_i), .sel_i(tog_sel_i), .tog_o(tog_now), .flag_o(flag_now)
   );

   tpoll_round_cnt #(.MAX_POLLS(MAX_POLLS)) u_rounds (
      .clk(clk), .rst_n(rst_n), .clr_i(round_clr), .inc_i(round_inc), .last_o(last_round)
   );

   always_comb begin
      st_d      = st_q;
      ok_d      = 1'b0;
      fail_d    = 1'b0;
      tmo_d     = 1'b0;
      round_clr = 1'b0;
      round_inc = 1'b0;
      if (st_q != PS_IDLE && abort_i) begin
         st_d = PS_IDLE;
      end else begin
         unique case (st_q)
            PS_IDLE: if (start_i) begin
               st_d      = PS_RD_A;
               round_clr = 1'b1;
            end
            PS_RD_A:  if (rd_ack_i) st_d = PS_RD_B;
            PS_RD_B:  if (rd_ack_i) begin
               if (tog_now == first_q) begin
                  st_d = PS_IDLE;
                  ok_d = 1'b1;
               end else if (flag_now) begin
                  st_d = PS_CHK_A;
               end else if (last_round) begin
                  st_d   = PS_IDLE;
                  fail_d = 1'b1;
                  tmo_d  = 1'b1;
               end else begin
                  st_d      = PS_RD_A;
                  round_inc = 1'b1;
               end
            end
            PS_CHK_A: if (rd_ack_i) st_d = PS_CHK_B;
            PS_CHK_B: if (rd_ack_i) begin
               if (tog_now == first_q) begin
                  st_d = PS_IDLE;
                  ok_d = 1'b1;
               end else begin
                  st_d = PS_RST_WR;
               end
            end
            PS_RST_WR: if (wr_ack_i) begin
               st_d   = PS_IDLE;
               fail_d = 1'b1;
            end
            default: st_d = PS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         first_q <= 1'b0;
         ok_q    <= 1'b0;
         fail_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         ok_q   <= ok_d;
         fail_q <= fail_d;
         tmo_q  <= tmo_d;
         if (rd_ack_i && (st_q == PS_RD_A || st_q == PS_CHK_A))
            first_q <= tog_now;
      end
   end

   assign rd_req_o    = (st_q == PS_RD_A) || (st_q == PS_RD_B) ||
                        (st_q == PS_CHK_A) || (st_q == PS_CHK_B);
   assign wr_req_o    = (st_q == PS_RST_WR);
   assign wr_data_o   = RST_CMD;
   assign busy_o      = (st_q != PS_IDLE);
   assign done_ok_o   = ok_q;
   assign done_fail_o = fail_q;
   assign timeout_o   = tmo_q;
endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RST_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              abort_i,
   input logic              rd_req_o,
   input logic              rd_ack_i,
   input logic              wr_req_o,
   input logic              wr_ack_i,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              busy_o,
   input logic              done_ok_o,
   input logic              done_fail_o,
   input logic              timeout_o
);
   assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok_o && done_fail_o));
   assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok_o || done_fail_o) |-> !busy_o);
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !abort_i) |=> busy_o);
   assert_pulse_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok_o || done_fail_o) |=> !(done_ok_o || done_fail_o));
   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);
   assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i && !abort_i) |=> wr_req_o);
   assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o));
   assert_cmd_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> (wr_data_o == RST_CMD));
   assert_tmo_with_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> done_fail_o);
   assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && abort_i) |=> !(done_ok_o || done_fail_o || busy_o));
endmodule

bind toggle_poll_ctrl tpoll_checker #(.DATA_W(DATA_W), .RST_CMD(RST_CMD)) u_tpoll_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
   .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i),
   .wr_data_o(wr_data_o), .busy_o(busy_o), .done_ok_o(done_ok_o),
   .done_fail_o(done_fail_o), .timeout_o(timeout_o)
);

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
   localparam int POLLS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, abort_i = 1'b0, tog_sel_i = 1'b0;
   logic       rd_ack_i = 1'b0, wr_ack_i = 1'b0;
   logic [7:0] rd_data_i = 8'h00;
   logic       rd_req_o, wr_req_o, busy_o, done_ok_o, done_fail_o, timeout_o;
   logic [7:0] wr_data_o;

   always #2.5 clk = ~clk;

   toggle_poll_ctrl #(.MAX_POLLS(POLLS)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .tog_sel_i(tog_sel_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i),
      .wr_data_o(wr_data_o), .busy_o(busy_o), .done_ok_o(done_ok_o),
      .done_fail_o(done_fail_o), .timeout_o(timeout_o)
   );

   typedef struct {
      bit    ok;
      bit    tmo;
      int    nrd;
      int    nwr;
      string tag;
   } exp_t;

   exp_t       expq[$];
   logic [7:0] script[$];
   int n_checks = 0, n_fail = 0;
   int reads_seen = 0, writes_seen = 0;
   logic [7:0] last_wr = 8'h00;

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      n_checks++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model: acknowledges each request one negedge after seeing it
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_ack_i) rd_ack_i = 1'b0;
         else if (rd_req_o) begin
            rd_ack_i  = 1'b1;
            rd_data_i = (script.size() > 0) ? script.pop_front() : 8'h00;
            reads_seen++;
         end
         if (wr_ack_i) wr_ack_i = 1'b0;
         else if (wr_req_o) begin
            wr_ack_i = 1'b1;
            last_wr  = wr_data_o;
            writes_seen++;
         end
      end
   end

   // monitor: pops one expectation per completion pulse
   always @(negedge clk) begin
      if (rst_n && (done_ok_o || done_fail_o)) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R9 unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(done_ok_o == e.ok, {e.tag, " outcome"}, done_ok_o, e.ok);
            chk(timeout_o == e.tmo, {e.tag, " timeout"}, timeout_o, e.tmo);
            chk(reads_seen == e.nrd, {e.tag, " reads"}, reads_seen, e.nrd);
            chk(writes_seen == e.nwr, {e.tag, " writes"}, writes_seen, e.nwr);
            if (e.nwr > 0) chk(last_wr == 8'hF0, {e.tag, " R6 cmd byte"}, last_wr, 8'hF0);
            chk(busy_o == 1'b0, {e.tag, " R2 busy at done"}, busy_o, 0);
         end
         reads_seen  = 0;
         writes_seen = 0;
      end
   end

   task automatic run_case(input bit sel, input bit ok, input bit tmo, input int nrd,
                           input int nwr, input string tag, input bit extra_start);
      exp_t e;
      e.ok = ok; e.tmo = tmo; e.nrd = nrd; e.nwr = nwr; e.tag = tag;
      expq.push_back(e);
      @(negedge clk);
      tog_sel_i = sel;
      start_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, {tag, " R2 busy after start"}, busy_o, 1);
      if (extra_start) begin
         @(negedge clk);
         @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 200 && expq.size() > 0; i++) @(negedge clk);
      chk(expq.size() == 0, {tag, " completion seen"}, expq.size(), 0);
      expq.delete();
      script.delete();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({busy_o, rd_req_o, wr_req_o, done_ok_o, done_fail_o, timeout_o} == 6'b0,
          "R1 outputs in reset", {busy_o, rd_req_o, wr_req_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy_o, rd_req_o, wr_req_o, done_ok_o, done_fail_o, timeout_o} == 6'b0,
          "R1 idle after reset", {busy_o, rd_req_o, wr_req_o}, 0);

      // R3: steady bit at once
      script = '{8'h00, 8'h00};
      run_case(1'b0, 1'b1, 1'b0, 2, 0, "R3 steady pair", 1'b0);
      // R4 + R10: toggling without flag, then steady; extra start mid-run
      script = '{8'h40, 8'h00, 8'h40, 8'h40};
      run_case(1'b0, 1'b1, 1'b0, 4, 0, "R4 R10 second round", 1'b1);
      // R5: flag raised, confirming round steady
      script = '{8'h00, 8'h60, 8'h60, 8'h60};
      run_case(1'b0, 1'b1, 1'b0, 4, 0, "R5 confirm steady", 1'b0);
      // R6: confirming round still toggles
      script = '{8'h00, 8'h60, 8'h20, 8'h60};
      run_case(1'b0, 1'b0, 1'b0, 4, 1, "R6 confirm toggles", 1'b0);
      // R11: bit stops in the same read that the flag rises
      script = '{8'h40, 8'h60};
      run_case(1'b0, 1'b1, 1'b0, 2, 0, "R11 stop with flag", 1'b0);
      // R7: watch bit 2; bit 6 moves but is ignored
      script = '{8'h04, 8'h00, 8'h40, 8'h00};
      run_case(1'b1, 1'b1, 1'b0, 4, 0, "R7 bit2 select", 1'b0);
      // R7: watch bit 6; bit 2 moves but is ignored
      script = '{8'h04, 8'h00};
      run_case(1'b0, 1'b1, 1'b0, 2, 0, "R7 bit6 select", 1'b0);
      // R8: budget exhausted
      for (int i = 0; i < POLLS; i++) begin
         script.push_back(8'h00);
         script.push_back(8'h40);
      end
      run_case(1'b0, 1'b0, 1'b1, 2 * POLLS, 0, "R8 budget", 1'b0);

      // R9: abort in the same cycle as a read acknowledge
      script = '{8'h40, 8'h00};
      @(negedge clk);
      tog_sel_i = 1'b0;
      start_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (reads_seen < 2) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk(busy_o == 1'b0, "R9 idle after abort", busy_o, 0);
      repeat (4) @(negedge clk);
      chk(rd_req_o == 1'b0, "R9 no read after abort", rd_req_o, 0);
      reads_seen = 0;
      script = '{8'h40, 8'h40};
      run_case(1'b0, 1'b1, 1'b0, 2, 0, "R9 fresh restart", 1'b0);

      chk(n_checks >= 12, "check count", n_checks, 12);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule